// File: doc/BRIEF.md
# MMU Fault Status Generator

This block sits between a processor's address path and its page lookup table. For each request it decides whether address translation applies. If it does not, the block passes the page-aligned address through unchanged with full permissions. If it does and the lookup hits, the block forms the physical page from the matching entry. If the lookup fails, the block raises a fault. It reports the fault as a compact status code, split by error kind and by fetch versus data access, with a separate flag for stores. It also latches the full faulting address.

The lookup table is external. The block receives the lookup result on the same cycle as the request. All results appear on registered outputs one clock after the request. After a fault, the block holds an exception-pending state until the exception handler clears it. A second fault that arrives while that state is still set is a fatal recursive fault and is reported on its own output.

Top module: `mmu_fault_gen`

## Requirements
- R1: Translation is available only when bit 3 of `cfg_main` is set. When bit 31 of `cfg_main` (the full-configuration flag) is also set, bits [1:0] of `cfg_ext` must both be 1 as well.
- R2: Translation applies only when it is available and `vm_on` is 1. Otherwise `phys_page` is the request address with its low PAGE_BITS bits cleared, and `perm` is 3'b111 (read, write, execute).
- R3: On a lookup hit under translation, `phys_page` = `lk_pbase` + ((address with low PAGE_BITS bits cleared) − `lk_vbase`), and `perm` = `lk_perm`.
- R4: A protection fault (`lk_hit`=0, `lk_prot`=1) gives a status code of 17 for an instruction fetch (`req_kind`=2) and 16 for a data access.
- R5: A miss (`lk_hit`=0, `lk_prot`=0) gives a status code of 19 for an instruction fetch and 18 for a data access.
- R6: Bit 10 of `fault_status` is 1 exactly when the faulting access is a store (`req_kind`=1). `req_kind` 0 is a load, and the value 3 is treated as a load.
- R7: On every reported fault, `fault_addr` holds the full, unmasked request address.
- R8: A fault that arrives while `fault_pend` is 1, and `exc_clear` is not asserted in the same cycle, pulses `rec_err` instead of `fault`. In that case `fault_status` and `fault_addr` keep the values from the first fault. `exc_clear` clears `fault_pend`, and a reported fault sets it.
- R9: The outputs `xlat_valid`, `fault` and `rec_err` are one-cycle strobes, registered one clock after `req_valid`. At most one of them is set in any cycle, and none is set without a request.
- R10: After reset, all strobes, `fault_pend`, `phys_page`, `perm`, `fault_status` and `fault_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Virtual access address |
| req_kind | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| cfg_main | input | CFG_W | Primary configuration word |
| cfg_ext | input | CFG_W | Secondary configuration word |
| vm_on | input | 1 | Virtual-mode bit of the status register |
| lk_hit | input | 1 | Lookup hit |
| lk_prot | input | 1 | Lookup protection error (used when there is no hit) |
| lk_vbase | input | ADDR_W | Virtual base of the matching entry |
| lk_pbase | input | ADDR_W | Physical base of the matching entry |
| lk_perm | input | 3 | Permissions of the matching entry |
| exc_clear | input | 1 | Exception handled; clears the pending state |
| xlat_valid | output | 1 | Page result valid strobe |
| phys_page | output | ADDR_W | Physical page address |
| perm | output | 3 | Page permissions {x,w,r} |
| fault | output | 1 | Fault strobe |
| fault_status | output | STAT_W | Exception status code |
| fault_addr | output | ADDR_W | Captured faulting address |
| fault_pend | output | 1 | MMU exception pending |
| rec_err | output | 1 | Recursive fault strobe |

## Verification
The assertions check on every cycle that the strobes are mutually exclusive and only follow a request, that a result page is always page-aligned, and that the store flag follows the request type. They also check that a reported fault leaves the pending state set and never arrives on top of an uncleared one, and that a recursive fault leaves the captured status and address unchanged. The bench scenarios show the rest: the exact status codes for each error kind and access type, the configuration-word decode, the hit address arithmetic and the identity mapping.

// File: rtl/mmu_fault_gen.sv
module mmu_fault_gen #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int STAT_W    = 32,
  parameter int CFG_W     = 32,
  parameter int PRES_BIT  = 3,
  parameter int FULL_BIT  = 31,
  parameter int EXT_LSB   = 0,
  parameter int EXT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [CFG_W-1:0]  cfg_main,
  input  logic [CFG_W-1:0]  cfg_ext,
  input  logic              vm_on,
  input  logic              lk_hit,
  input  logic              lk_prot,
  input  logic [ADDR_W-1:0] lk_vbase,
  input  logic [ADDR_W-1:0] lk_pbase,
  input  logic [2:0]        lk_perm,
  input  logic              exc_clear,
  output logic              xlat_valid,
  output logic [ADDR_W-1:0] phys_page,
  output logic [2:0]        perm,
  output logic              fault,
  output logic [STAT_W-1:0] fault_status,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              fault_pend,
  output logic              rec_err
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;
  localparam int STORE_BIT = 10;

  logic              avail, translate, page_ok, bad, recursive;
  logic [ADDR_W-1:0] vpage, page_out;
  logic [2:0]        perm_out;
  logic [STAT_W-1:0] code;

  assign avail     = cfg_main[PRES_BIT] && (!cfg_main[FULL_BIT] || (&cfg_ext[EXT_LSB +: EXT_W]));
  assign translate = avail && vm_on;
  assign vpage     = req_addr & PAGE_MASK;
  assign page_ok   = req_valid && (!translate || lk_hit);
  assign bad       = req_valid && translate && !lk_hit;
  assign recursive = bad && fault_pend && !exc_clear;
  assign page_out  = translate ? ((lk_pbase + (vpage - lk_vbase)) & PAGE_MASK) : vpage;
  assign perm_out  = translate ? lk_perm : 3'b111;

  always_comb begin
    code = '0;
    code[4:0] = lk_prot ? 5'd16 : 5'd18;
    if (req_kind == KIND_FETCH) code[0] = 1'b1;
    code[STORE_BIT] = (req_kind == KIND_STORE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlat_valid   <= 1'b0;
      fault        <= 1'b0;
      rec_err      <= 1'b0;
      fault_pend   <= 1'b0;
      phys_page    <= '0;
      perm         <= '0;
      fault_status <= '0;
      fault_addr   <= '0;
    end else begin
      xlat_valid <= page_ok;
      fault      <= bad && !recursive;
      rec_err    <= recursive;
      fault_pend <= (fault_pend && !exc_clear) || (bad && !recursive);
      if (page_ok) begin
        phys_page <= page_out;
        perm      <= perm_out;
      end
      if (bad && !recursive) begin
        fault_status <= code;
        fault_addr   <= req_addr;
      end
    end
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({xlat_valid, fault, rec_err}) <= 1);
  assert_strobe_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_valid || fault || rec_err) |-> $past(req_valid));
  assert_page_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_valid |-> ((phys_page & ~PAGE_MASK) == '0));
  assert_store_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_status[STORE_BIT] == ($past(req_kind) == KIND_STORE)));
  assert_fault_sets_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_pend);
  assert_no_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!$past(fault_pend) || $past(exc_clear)));
  assert_rec_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_err |-> ($stable(fault_status) && $stable(fault_addr)));
  assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_status[4:0] >= 5'd16 && fault_status[4:0] <= 5'd19));
endmodule

// File: tb/mmu_fault_gen_bench.sv
module mmu_fault_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [31:0] cfg_main = 32'h8;
  logic [31:0] cfg_ext = '0;
  logic        vm_on = 1'b0;
  logic        lk_hit = 1'b0;
  logic        lk_prot = 1'b0;
  logic [31:0] lk_vbase = '0;
  logic [31:0] lk_pbase = '0;
  logic [2:0]  lk_perm = '0;
  logic        exc_clear = 1'b0;
  logic        xlat_valid, fault, fault_pend, rec_err;
  logic [31:0] phys_page, fault_status, fault_addr;
  logic [2:0]  perm;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmu_fault_gen u_mmu_fault_gen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] k, input logic hit,
                        input logic prot, input logic clr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; lk_hit = hit; lk_prot = prot; exc_clear = clr;
    @(negedge clk);
    req_valid = 1'b0; exc_clear = 1'b0;
  endtask

  task automatic clear_pending();
    @(negedge clk); exc_clear = 1'b1;
    @(negedge clk); exc_clear = 1'b0;
    chk("R8 pending cleared", {31'd0, fault_pend}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 strobes", {29'd0, xlat_valid, fault, rec_err}, 32'd0);
    chk("R10 pending", {31'd0, fault_pend}, 32'd0);
    chk("R10 status", fault_status, 32'd0);
    chk("R10 address", fault_addr | phys_page | {29'd0, perm}, 32'd0);
  endtask

  task automatic t_identity();
    vm_on = 1'b0; cfg_main = 32'h8;
    access(32'h1234_5678, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 identity strobe", {30'd0, xlat_valid, fault}, 32'd2);
    chk("R2 identity page", phys_page, 32'h1234_5000);
    chk("R2 identity perm", {29'd0, perm}, 32'd7);
    @(negedge clk);
    chk("R9 strobe one cycle", {29'd0, xlat_valid, fault, rec_err}, 32'd0);
  endtask

  task automatic t_avail();
    vm_on = 1'b1; cfg_main = 32'h0;
    access(32'hABCD_E123, 2'd2, 1'b0, 1'b0, 1'b0);
    chk("R1 no present bit identity", phys_page, 32'hABCD_E000);
    cfg_main = 32'h8000_0008; cfg_ext = 32'h1;
    access(32'h0F0F_0F0F, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R1 partial ext field identity", {31'd0, fault}, 32'd0);
    chk("R1 partial ext page", phys_page, 32'h0F0F_0000);
    cfg_ext = 32'h3;
    lk_vbase = 32'h4000_0000; lk_pbase = 32'h8010_0000; lk_perm = 3'b101;
    access(32'h4000_1234, 2'd0, 1'b1, 1'b0, 1'b0);
    chk("R1 full config translates", phys_page, 32'h8010_1000);
  endtask

  task automatic t_hit();
    cfg_main = 32'h8; vm_on = 1'b1;
    lk_vbase = 32'h0002_0000; lk_pbase = 32'h7700_0000; lk_perm = 3'b011;
    access(32'h0002_3ABC, 2'd1, 1'b1, 1'b0, 1'b0);
    chk("R3 hit strobe", {30'd0, xlat_valid, fault}, 32'd2);
    chk("R3 hit page", phys_page, 32'h7700_3000);
    chk("R3 hit perm", {29'd0, perm}, 32'd3);
  endtask

  task automatic t_faults();
    access(32'h1111_2222, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R4 prot load strobe", {30'd0, xlat_valid, fault}, 32'd1);
    chk("R4 prot load code", fault_status, 32'd16);
    chk("R7 address", fault_addr, 32'h1111_2222);
    clear_pending();
    access(32'h2222_3333, 2'd2, 1'b0, 1'b1, 1'b0);
    chk("R4 prot fetch code", fault_status, 32'd17);
    clear_pending();
    access(32'h3333_4445, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R6 prot store code", fault_status, 32'h410);
    clear_pending();
    access(32'h4444_5557, 2'd1, 1'b0, 1'b0, 1'b0);
    chk("R5 R6 miss store code", fault_status, 32'h412);
    chk("R7 miss address", fault_addr, 32'h4444_5557);
    clear_pending();
    access(32'h5555_6669, 2'd2, 1'b0, 1'b0, 1'b0);
    chk("R5 miss fetch code", fault_status, 32'd19);
    clear_pending();
    access(32'h6666_0001, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R5 miss load code", fault_status, 32'd18);
    access(32'h6666_0002, 2'd3, 1'b0, 1'b0, 1'b1);
    chk("R6 kind 3 as load", fault_status, 32'd18);
    chk("R8 clear with fault not recursive", {30'd0, fault, rec_err}, 32'd2);
  endtask

  task automatic t_recursive();
    chk("R8 pending set", {31'd0, fault_pend}, 32'd1);
    access(32'h9999_AAAA, 2'd2, 1'b0, 1'b1, 1'b0);
    chk("R8 recursive strobe", {29'd0, xlat_valid, fault, rec_err}, 32'd1);
    chk("R8 status held", fault_status, 32'd18);
    chk("R8 address held", fault_addr, 32'h6666_0002);
    chk("R8 still pending", {31'd0, fault_pend}, 32'd1);
    clear_pending();
    access(32'h9999_AAAA, 2'd2, 1'b0, 1'b1, 1'b0);
    chk("R8 fault after clear", {30'd0, fault, rec_err}, 32'd2);
    chk("R8 new code", fault_status, 32'd17);
  endtask

  task automatic t_idle();
    @(negedge clk); lk_hit = 1'b0; req_addr = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R9 no request no strobe", {29'd0, xlat_valid, fault, rec_err}, 32'd0);
    chk("R9 no request address kept", fault_addr, 32'h9999_AAAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_identity();
    t_avail();
    t_hit();
    t_faults();
    t_recursive();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule